// File: doc/BRIEF.md
# Serial Command/Data Byte Receiver

This block takes bytes from a slow, externally clocked serial link and hands them to on-chip logic one at a time. A host drives a serial clock and a data line, selects the block with an active-low select, and sets a flag that marks each byte as either a command or display data. The block brings the serial clock and the select into the system clock domain and detects their edges there. It shifts eight bits in, most significant bit first, and then presents the complete byte together with its tag.

After every eighth bit the block pulls an active-low busy line low, and it ignores the serial clock until downstream logic acknowledges the byte. The busy line is meant to drive a three-state pad, and its enable is off while the select is high. A falling select gives a one-cycle pulse that downstream logic uses to return its write pointer to address 0. A rising select gives a one-cycle pulse that asks for a copy of the stored data into the display latch.

Top module: `serial_cmd_rx`

## Requirements
- R1: On each accepted rising edge of the serial clock, the block samples the data line and shifts it in, most significant bit first. After eight accepted edges, `byte_o` holds the first sampled bit in bit 7 and the last sampled bit in bit 0.
- R2: On the eighth accepted bit, `byte_vld_o` pulses high for exactly one cycle, and `busy_n_o` is low in that same cycle.
- R3: `byte_is_cmd_o` is 1 when the command/data flag was high at the eighth bit, which marks a command. It is 0 when the flag was low, which marks data.
- R4: While `busy_n_o` is low, serial clock edges are ignored. No new byte is produced, and bits clocked in during that time do not appear in any later byte.
- R5: While the select is high, serial clock edges are ignored whatever the busy state, and no byte is produced.
- R6: A falling edge of the select clears the bit count, so a partial byte is discarded. It also releases busy and emits a one-cycle `ptr_rst_o` pulse.
- R7: A rising edge of the select emits exactly one one-cycle `xfer_req_o` pulse.
- R8: `busy_oe_o` is high only while the synchronized select is low. It follows the select pin after two system clocks.
- R9: While busy, `byte_o` and `byte_is_cmd_o` hold steady. Busy is released, with `busy_n_o` going high, one cycle after `ack_i` is seen high.
- R10: After reset, `busy_n_o` is 1, `byte_o` is 0, and no pulse output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial shift clock, idle high |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_cs_n_i | input | 1 | Active-low select |
| ser_cd_i | input | 1 | 1 = command, 0 = data |
| ack_i | input | 1 | Downstream acknowledge of the held byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |
| byte_o | output | 8 | Last received byte |
| byte_is_cmd_o | output | 1 | Tag of the last received byte |
| busy_n_o | output | 1 | Active-low busy |
| busy_oe_o | output | 1 | Output enable for the busy pad |
| ptr_rst_o | output | 1 | Pulse on select falling edge |
| xfer_req_o | output | 1 | Pulse on select rising edge |

## Verification
The assertions check on every cycle that the strobe and the busy line agree, and that the two select pulses each last a single cycle. They also check that no byte appears while busy, that the held byte stays still while busy, and that the pad enable tracks the select after its two-stage delay. Only the bench's scenarios can show that the bits land in the right order and that the tag is right. The same holds for discarding bits clocked while busy or deselected, for clearing a half-received byte on a new select, and for busy being released after an acknowledge.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] shreg;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] hold;
        logic              is_cmd;
        logic              busy;
        logic              ack_seen;
        logic              vld;
        logic              ptr_rst;
        logic              xfer;
    } rx_state_t;
endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] pipe_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {STAGES{RST_VAL[b]}};
            else        pipe_q <= {pipe_q[STAGES-2:0], async_i[b]};
        end
        assign sync_o[b] = pipe_q[LAST];
    end
endmodule

// File: rtl/srx_edge.sv
module srx_edge #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl_i;
    end

    assign rise_o = lvl_i & ~prev_q;
    assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/srx_core.sv
module srx_core
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_rise_i,
    input  logic              cs_n_i,
    input  logic              cs_fall_i,
    input  logic              cs_rise_i,
    input  logic              dat_i,
    input  logic              cd_i,
    input  logic              ack_i,
    output logic              vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              is_cmd_o,
    output logic              busy_o,
    output logic              ptr_rst_o,
    output logic              xfer_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.vld     = 1'b0;
        st_d.ptr_rst = 1'b0;
        st_d.xfer    = 1'b0;

        if (st_q.busy) begin
            if (st_q.ack_seen) begin
                st_d.busy     = 1'b0;
                st_d.ack_seen = 1'b0;
            end else if (ack_i) begin
                st_d.ack_seen = 1'b1;
            end
        end else if (sck_rise_i && !cs_n_i) begin
            st_d.shreg = {st_q.shreg[BYTE_W-2:0], dat_i};
            if (st_q.cnt == LAST_BIT) begin
                st_d.cnt    = '0;
                st_d.hold   = {st_q.shreg[BYTE_W-2:0], dat_i};
                st_d.is_cmd = cd_i;
                st_d.vld    = 1'b1;
                st_d.busy   = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end

        if (cs_fall_i) begin
            st_d.cnt      = '0;
            st_d.busy     = 1'b0;
            st_d.ack_seen = 1'b0;
            st_d.vld      = 1'b0;
            st_d.ptr_rst  = 1'b1;
        end else if (cs_rise_i) begin
            st_d.xfer = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vld_o     = st_q.vld;
    assign byte_o    = st_q.hold;
    assign is_cmd_o  = st_q.is_cmd;
    assign busy_o    = st_q.busy;
    assign ptr_rst_o = st_q.ptr_rst;
    assign xfer_o    = st_q.xfer;
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
    import serial_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk_i,
    input  logic              ser_dat_i,
    input  logic              ser_cs_n_i,
    input  logic              ser_cd_i,
    input  logic              ack_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_is_cmd_o,
    output logic              busy_n_o,
    output logic              busy_oe_o,
    output logic              ptr_rst_o,
    output logic              xfer_req_o
);
    // bit order: 3 = cd, 2 = dat, 1 = cs_n, 0 = sck
    logic [3:0] raw, synced;
    logic [1:0] rise, fall;
    logic       busy;

    assign raw = {ser_cd_i, ser_dat_i, ser_cs_n_i, ser_clk_i};

    srx_sync #(.WIDTH(4), .STAGES(2), .RST_VAL(4'b0011)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(raw), .sync_o(synced)
    );

    srx_edge #(.WIDTH(2), .RST_VAL(2'b11)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl_i(synced[1:0]),
        .rise_o(rise), .fall_o(fall)
    );

    srx_core u_core (
        .clk(clk), .rst_n(rst_n),
        .sck_rise_i(rise[0]), .cs_n_i(synced[1]),
        .cs_fall_i(fall[1]), .cs_rise_i(rise[1]),
        .dat_i(synced[2]), .cd_i(synced[3]), .ack_i(ack_i),
        .vld_o(byte_vld_o), .byte_o(byte_o), .is_cmd_o(byte_is_cmd_o),
        .busy_o(busy), .ptr_rst_o(ptr_rst_o), .xfer_o(xfer_req_o)
    );

    assign busy_n_o  = ~busy;
    assign busy_oe_o = ~synced[1];
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ser_cs_n_i,
    input logic       byte_vld_o,
    input logic [7:0] byte_o,
    input logic       byte_is_cmd_o,
    input logic       busy_n_o,
    input logic       busy_oe_o,
    input logic       ptr_rst_o,
    input logic       xfer_req_o
);
    p_vld_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        byte_vld_o |-> !busy_n_o);

    p_no_byte_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_n_o |=> !byte_vld_o);

    p_ptr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_rst_o |=> !ptr_rst_o);

    p_xfer_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req_o |=> !xfer_req_o);

    p_oe_track_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_oe_o == !$past(ser_cs_n_i, 2));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n_o && !byte_vld_o) |-> ($stable(byte_o) && $stable(byte_is_cmd_o)));
endmodule

bind serial_cmd_rx serial_cmd_rx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ser_cs_n_i(ser_cs_n_i),
    .byte_vld_o(byte_vld_o), .byte_o(byte_o), .byte_is_cmd_o(byte_is_cmd_o),
    .busy_n_o(busy_n_o), .busy_oe_o(busy_oe_o),
    .ptr_rst_o(ptr_rst_o), .xfer_req_o(xfer_req_o)
);

// File: tb/serial_cmd_rx_tb_top.sv
module serial_cmd_rx_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b1, ser_dat = 1'b0, ser_cs_n = 1'b1, ser_cd = 1'b0, ack = 1'b0;
    logic       byte_vld, byte_is_cmd, busy_n, busy_oe, ptr_rst, xfer_req;
    logic [7:0] byte_q;

    int total = 0;
    int bad = 0;
    int vld_cnt = 0, ptr_cnt = 0, xfer_cnt = 0;
    logic [7:0] cap_byte = '0;
    logic       cap_cmd = 1'b0;

    always #4 clk = ~clk;

    serial_cmd_rx dut_i (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_cs_n_i(ser_cs_n),
        .ser_cd_i(ser_cd), .ack_i(ack),
        .byte_vld_o(byte_vld), .byte_o(byte_q), .byte_is_cmd_o(byte_is_cmd),
        .busy_n_o(busy_n), .busy_oe_o(busy_oe),
        .ptr_rst_o(ptr_rst), .xfer_req_o(xfer_req)
    );

    always @(negedge clk) begin
        if (byte_vld) begin
            vld_cnt++;
            cap_byte = byte_q;
            cap_cmd  = byte_is_cmd;
        end
        if (ptr_rst)  ptr_cnt++;
        if (xfer_req) xfer_cnt++;
    end

    // bit 8 = command flag, bits 7:0 = byte
    localparam logic [8:0] VEC [8] = '{9'h1A5, 9'h03C, 9'h100, 9'h0FF,
                                       9'h181, 9'h07E, 9'h155, 9'h0AA};

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic cd);
        ser_dat = b;
        ser_cd  = cd;
        ser_clk = 1'b0;
        repeat (6) @(negedge clk);
        ser_clk = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input logic cd);
        for (int i = 7; i >= 0; i--) send_bit(v[i], cd);
        repeat (4) @(negedge clk);
    endtask

    task automatic set_cs(input logic v);
        ser_cs_n = v;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v0, p0, x0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 reset state
        chk(busy_n == 1'b1, "R10 busy_n", busy_n, 1);
        chk(byte_q == 8'h00, "R10 byte", byte_q, 0);
        chk(!byte_vld && !ptr_rst && !xfer_req, "R10 pulses", vld_cnt, 0);
        chk(busy_oe == 1'b0, "R8 oe off when deselected", busy_oe, 0);

        // R5: clocks with select high are ignored
        send_byte(8'h5A, 1'b1);
        chk(vld_cnt == 0, "R5 no byte while deselected", vld_cnt, 0);
        chk(busy_n == 1'b1, "R5 busy stays high", busy_n, 1);

        // R6 select fall pulse
        p0 = ptr_cnt;
        set_cs(1'b0);
        chk(ptr_cnt == p0 + 1, "R6 ptr_rst pulse", ptr_cnt, p0 + 1);
        chk(busy_oe == 1'b1, "R8 oe on when selected", busy_oe, 1);

        // Table walk: R1 R2 R3 R9
        for (int k = 0; k < 8; k++) begin
            v0 = vld_cnt;
            send_byte(VEC[k][7:0], VEC[k][8]);
            chk(vld_cnt == v0 + 1, "R2 one strobe", vld_cnt, v0 + 1);
            chk(cap_byte == VEC[k][7:0], "R1 byte value", cap_byte, VEC[k][7:0]);
            chk(cap_cmd == VEC[k][8], "R3 cmd tag", cap_cmd, VEC[k][8]);
            chk(busy_n == 1'b0, "R2 busy low", busy_n, 0);
            chk(byte_q == VEC[k][7:0], "R9 byte held", byte_q, VEC[k][7:0]);
            do_ack();
            chk(busy_n == 1'b1, "R9 busy released", busy_n, 1);
        end

        // R7 select rise
        x0 = xfer_cnt;
        set_cs(1'b1);
        chk(xfer_cnt == x0 + 1, "R7 xfer pulse", xfer_cnt, x0 + 1);
        chk(busy_oe == 1'b0, "R8 oe off again", busy_oe, 0);

        // R4: bits while busy are dropped
        set_cs(1'b0);
        v0 = vld_cnt;
        send_byte(8'h11, 1'b0);
        send_byte(8'hEE, 1'b1);
        chk(vld_cnt == v0 + 1, "R4 no byte while busy", vld_cnt, v0 + 1);
        chk(byte_q == 8'h11 && !byte_is_cmd, "R4 held byte intact", byte_q, 8'h11);
        do_ack();
        send_byte(8'h22, 1'b1);
        chk(cap_byte == 8'h22 && cap_cmd, "R4 next byte clean", cap_byte, 8'h22);
        do_ack();

        // R6: partial byte discarded by select re-fall
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        set_cs(1'b1);
        p0 = ptr_cnt;
        set_cs(1'b0);
        chk(ptr_cnt == p0 + 1, "R6 ptr_rst on re-select", ptr_cnt, p0 + 1);
        v0 = vld_cnt;
        send_byte(8'h5A, 1'b0);
        chk(vld_cnt == v0 + 1 && cap_byte == 8'h5A, "R6 partial discarded", cap_byte, 8'h5A);

        // R6: select fall releases busy without ack
        set_cs(1'b1);
        set_cs(1'b0);
        chk(busy_n == 1'b1, "R6 busy released by select", busy_n, 1);
        set_cs(1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule